// File: doc/BRIEF.md
# Banked Serial Configuration Loader

This block takes configuration writes over a write-only three-wire link: a serial clock, an active-low select line and one data line. While select is low, the block gathers data bits into 8-bit words. Each word goes to the next register address, and the block steps that address on its own. A frame always opens with the word for address 0. Bit 0 of that word picks the bank for the rest of the frame. The following words then land either at address 1 and upward, or at address 14 and upward.

Words are collected in a shadow copy. When select returns high, every byte loaded in that frame moves into the live image in the same system clock cycle. The live image is 27 bytes wide and presented as one flat vector, with byte i at bits [8i+7:8i].

The three serial lines are sampled through synchronizers in the system clock domain. Edges are found on the synchronized lines, so the serial clock must be several times slower than the system clock.

Top module: `cfg_serial_loader`

## Requirements
- R1: While rst_n is low, the image equals the RESET_IMAGE parameter, which is all zero by default.
- R2: Each word is 8 bits, sent least significant bit first, sampled on rising serial clock edges while select is low. The first word of a frame is stored at address 0.
- R3: When bit 0 of the address-0 word is 0, the next word goes to address 1. Each further word goes to the address one above the previous one.
- R4: When bit 0 of the address-0 word is 1, the next word goes to address 14. Each further word goes to the address one above the previous one.
- R5: The image does not change while select is low, and it does not change in the first two system clock cycles after select rises.
- R6: On commit, only the addresses written during the frame take new values. All other bytes keep their previous values.
- R7: Words that would fall beyond address 26 are dropped, and they leave no trace.
- R8: Bits of an incomplete final word are dropped. Complete words from the same frame are still committed.
- R9: Serial clock edges while select is high do not change the image and do not disturb the bit alignment of the next frame.
- R10: The commit appears on the image in the third system clock cycle after select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock, asynchronous to clk |
| sload_n | input | 1 | Active-low frame select |
| sdata | input | 1 | Serial data |
| regs_o | output | NREGS*8 | Live register image, byte i at [8i+7:8i] |

## Verification
The hardest cases to reach are the ones with a broken frame.

- **Overrunning frame:** a bank-2 frame runs past the last address. The bench checks that the overflow words are dropped and nothing wraps back to low addresses.
- **Partial word:** a frame ends with a partial word. The bench checks that its complete words still commit.

The bench builds both kinds of frame directly from the driver, by sending surplus bytes and then a few loose bits before raising select.

It also toggles the serial clock with select high, then sends a normal frame. A bit slipped into the shift register would misplace every byte of that next frame.

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader #(
  parameter int NREGS       = 27,
  parameter int BANK2_BASE  = 14,
  parameter int SYNC_STAGES = 2,
  parameter logic [NREGS*8-1:0] RESET_IMAGE = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sck,
  input  logic               sload_n,
  input  logic               sdata,
  output logic [NREGS*8-1:0] regs_o
);
  localparam int AW = $clog2(NREGS + 1);

  logic [SYNC_STAGES-1:0] sck_sy, sl_sy, sd_sy;
  logic sck_d, sl_d;
  logic [2:0] bitcnt;
  logic [7:0] shreg;
  logic [AW-1:0] addr, addr_nxt;
  logic [NREGS-1:0] wr;
  logic [7:0] shadow [NREGS];
  logic [NREGS*8-1:0] live;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_sy <= '0;
      sl_sy  <= '1;
      sd_sy  <= '0;
      sck_d  <= 1'b0;
      sl_d   <= 1'b1;
    end else begin
      sck_sy <= {sck_sy[SYNC_STAGES-2:0], sck};
      sl_sy  <= {sl_sy[SYNC_STAGES-2:0], sload_n};
      sd_sy  <= {sd_sy[SYNC_STAGES-2:0], sdata};
      sck_d  <= sck_sy[SYNC_STAGES-1];
      sl_d   <= sl_sy[SYNC_STAGES-1];
    end

  wire sck_q     = sck_sy[SYNC_STAGES-1];
  wire sl_q      = sl_sy[SYNC_STAGES-1];
  wire sd_q      = sd_sy[SYNC_STAGES-1];
  wire sl_fall   = !sl_q && sl_d;
  wire sl_rise   = sl_q && !sl_d;
  wire shift     = sck_q && !sck_d && !sl_q;
  wire word_done = shift && (bitcnt == 3'd7);
  wire [7:0] word = {sd_q, shreg[7:1]};

  always_comb begin
    if (addr == '0)
      addr_nxt = word[0] ? AW'(BANK2_BASE) : AW'(1);
    else if (addr < AW'(NREGS))
      addr_nxt = addr + AW'(1);
    else
      addr_nxt = addr;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bitcnt <= '0;
      shreg  <= '0;
      addr   <= '0;
    end else if (sl_fall) begin
      bitcnt <= '0;
      addr   <= '0;
    end else if (shift) begin
      bitcnt <= bitcnt + 3'd1;
      shreg  <= word;
      if (word_done) addr <= addr_nxt;
    end

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    wire hit = word_done && (addr == AW'(i));

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        shadow[i] <= '0;
        wr[i]     <= 1'b0;
      end else if (sl_fall) begin
        wr[i] <= 1'b0;
      end else if (hit) begin
        shadow[i] <= word;
        wr[i]     <= 1'b1;
      end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)
        live[i*8 +: 8] <= RESET_IMAGE[i*8 +: 8];
      else if (sl_rise && wr[i])
        live[i*8 +: 8] <= shadow[i];
  end

  assign regs_o = live;
endmodule

module cfg_serial_loader_chk #(
  parameter int NREGS      = 27,
  parameter int BANK2_BASE = 14,
  parameter int AW         = 5,
  parameter logic [NREGS*8-1:0] RESET_IMAGE = '0
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sl_q,
  input logic               word_done,
  input logic [7:0]         word,
  input logic [2:0]         bitcnt,
  input logic [AW-1:0]      addr,
  input logic [NREGS*8-1:0] regs_o
);
  // R1
  reset_image_chk: assert property (@(posedge clk) !rst_n |-> regs_o == RESET_IMAGE);

  // R5
  hold_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sl_q |=> $stable(regs_o));

  // R3
  bank1_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && addr == '0 && !word[0]) |=> addr == AW'(1));

  // R4
  bank2_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && addr == '0 && word[0]) |=> addr == AW'(BANK2_BASE));

  // R7
  addr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr <= AW'(NREGS));

  // R9
  idle_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sl_q |=> $stable(bitcnt));
endmodule

bind cfg_serial_loader cfg_serial_loader_chk #(
  .NREGS(NREGS), .BANK2_BASE(BANK2_BASE), .AW(AW), .RESET_IMAGE(RESET_IMAGE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sl_q(sl_q), .word_done(word_done),
  .word(word), .bitcnt(bitcnt), .addr(addr), .regs_o(regs_o)
);

// File: tb/tb_cfg_serial_loader.sv
module tb_cfg_serial_loader;
  localparam int NREGS = 27;
  localparam int W = NREGS * 8;

  logic clk = 0, rst_n = 0, sck = 0, sload_n = 1, sdata = 0;
  logic [W-1:0] regs_o;

  cfg_serial_loader dut (.clk(clk), .rst_n(rst_n), .sck(sck), .sload_n(sload_n),
                         .sdata(sdata), .regs_o(regs_o));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  logic [7:0] model [NREGS];
  logic [7:0] fb [40];
  logic [W-1:0] exp_q [$];
  logic [W-1:0] prev_exp;
  string tag_q [$];
  event commit_ev;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] image();
    logic [W-1:0] v;
    for (int i = 0; i < NREGS; i++) v[i*8 +: 8] = model[i];
    return v;
  endfunction

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    sck = 0; sdata = b; wait_n(4);
    sck = 1; wait_n(4);
  endtask

  task automatic send_frame(input int n, input int extra_bits, input string tag);
    int a = 0;
    for (int k = 0; k < n; k++) begin
      if (a < NREGS) model[a] = fb[k];
      if (a == 0) a = fb[k][0] ? 14 : 1;
      else if (a < NREGS) a++;
    end
    exp_q.push_back(image());
    tag_q.push_back(tag);
    @(negedge clk); sload_n = 0; wait_n(4);
    for (int k = 0; k < n; k++)
      for (int j = 0; j < 8; j++) send_bit(fb[k][j]);
    for (int j = 0; j < extra_bits; j++) send_bit(j[0]);
    sck = 0; wait_n(4);
    sload_n = 1;
    -> commit_ev;
    wait_n(12);
  endtask

  initial begin
    logic [W-1:0] old;
    logic [W-1:0] e;
    string t;
    forever begin
      @(commit_ev);
      old = regs_o;
      check(old == prev_exp, "R5 image changed during frame", old, prev_exp);
      repeat (2) @(posedge clk);
      @(negedge clk);
      check(regs_o == old, "R5 image changed before third cycle", regs_o, old);
      @(posedge clk);
      @(negedge clk);
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(regs_o == e, {"R10 commit ", t}, regs_o, e);
      prev_exp = e;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NREGS; i++) model[i] = 8'h00;
    prev_exp = '0;
    wait_n(5);
    check(regs_o == '0, "R1 reset image", regs_o, '0);
    rst_n = 1;
    wait_n(5);
    check(regs_o == '0, "R1 image after reset release", regs_o, '0);

    // R2 R3 bank 1, short frame
    fb[0] = 8'h80; fb[1] = 8'h3C; fb[2] = 8'hC5;
    send_frame(3, 0, "R2 R3 bank1 frame");

    // R4 R6 bank 2, bytes 14..16, bytes 1..2 must persist
    fb[0] = 8'h01; fb[1] = 8'hA1; fb[2] = 8'h5E; fb[3] = 8'h0F;
    send_frame(4, 0, "R4 R6 bank2 frame");

    // R7 overrun past 26
    fb[0] = 8'h41;
    for (int k = 1; k <= 15; k++) fb[k] = 8'(8'h10 + k * 7);
    send_frame(16, 0, "R7 overrun discarded");

    // R8 partial trailing word
    fb[0] = 8'h22; fb[1] = 8'h99;
    send_frame(2, 5, "R8 partial word dropped");

    // R3 R6 full bank 1
    for (int k = 0; k < 14; k++) fb[k] = 8'((k * 37 + 6) & 8'hFE);
    send_frame(14, 0, "R3 R6 full bank1");

    // R9 clock activity with select high
    for (int j = 0; j < 5; j++) send_bit(1'b1);
    sck = 0; wait_n(8);
    check(regs_o == prev_exp, "R9 idle clocks changed image", regs_o, prev_exp);
    fb[0] = 8'h01; fb[1] = 8'h6B;
    send_frame(2, 0, "R9 alignment after idle clocks");

    wait_n(10);
    check(exp_q.size() == 0, "R10 pending commits", W'(exp_q.size()), '0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule